// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block sits between a UART receive shifter and its receive buffer. It keeps the sticky error and status flags of the receiver: overrun, noise, framing error, parity error and idle. It also gates the receive-data-ready indication. Each completed character arrives as a one-cycle event together with its stop bit value, a parity mismatch indication, a noise indication and the state of break-detect mode. From these inputs and the buffer's fullness the block decides in the same cycle whether the character is written into the buffer. It also decides which parity-error tag goes with the stored word.

Software clears a flag in two steps. First it reads the status register while the flag is set. Then it reads the data register. A new event that sets the same flag between the two reads cancels the pending clear, so a fresh error is never lost. An overrun discards the incoming character and keeps the other error flags of that character from setting. While the overrun flag is set, no further characters are stored, and the ready and idle indications cannot become active.

Top module: `uart_rx_flag_ctrl`

## Requirements
- R1: After reset all flags (ovr_flg, nse_flg, frm_flg, par_flg, idle_flg, rdy_flg) read 0 and push is 0.
- R2: A character that completes with stop bit 1, no noise, no parity mismatch, room in the buffer and no flag blocking is pushed in its completion cycle with push_perr 0, and no flag sets.
- R3: A character that completes while buf_full is 1 sets ovr_flg one cycle later and is not pushed. nse_flg, frm_flg and par_flg do not set for that character.
- R4: While ovr_flg is 1 no character is pushed, even with room in the buffer, and completed characters set none of nse_flg, frm_flg or par_flg.
- R5: While ovr_flg is 1, rdy_flg and idle_flg make no 0-to-1 transition. rdy_flg otherwise follows buf_nempty with one cycle of delay.
- R6: A character completing with stop bit 0 outside break-detect mode sets frm_flg and is still pushed. While frm_flg is 1, completed characters are neither pushed nor flagged.
- R7: par_flg sets only when par_en is 1, brk_mode is 0 and par_bad is 1 for a pushed character. push_perr is 1 exactly for such a character.
- R8: A pushed character with noise_hit 1 outside break-detect mode sets nse_flg.
- R9: With brk_mode 1, nse_flg, frm_flg and par_flg never set. A character completing while brk_pend is 1 sets ovr_flg and is not pushed.
- R10: A flag clears only on a data_rd that follows a stat_rd which saw the flag set. data_rd alone leaves every flag unchanged.
- R11: If the flag's set event recurs between the arming stat_rd and the data_rd, the data_rd leaves the flag set.
- R12: idle_evt sets idle_flg when ovr_flg is 0, and idle_flg clears by the same two-step read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chr_done | input | 1 | One-cycle pulse: stop bit of a character fully received |
| stop_bit | input | 1 | Sampled stop bit value of the completing character |
| par_bad | input | 1 | Received parity differs from computed parity |
| par_en | input | 1 | Parity checking enabled |
| noise_hit | input | 1 | Noise seen while sampling the character |
| brk_mode | input | 1 | Break-detect mode enabled |
| brk_pend | input | 1 | Break flag set and not yet cleared |
| buf_full | input | 1 | Receive buffer has no room |
| buf_nempty | input | 1 | Receive buffer holds at least one word |
| idle_evt | input | 1 | One-cycle pulse: idle line detected |
| stat_rd | input | 1 | One-cycle status register read strobe |
| data_rd | input | 1 | One-cycle data register read strobe |
| push | output | 1 | Write the completing character into the buffer (combinational) |
| push_perr | output | 1 | Parity-error tag stored with the pushed word |
| ovr_flg | output | 1 | Overrun flag |
| nse_flg | output | 1 | Noise flag |
| frm_flg | output | 1 | Framing error flag |
| par_flg | output | 1 | Parity error flag |
| idle_flg | output | 1 | Idle flag |
| rdy_flg | output | 1 | Receive data ready indication |

## Verification
Characters are sent as clean, parity-bad with checking both on and off, noisy, and with a zero stop bit. Comparing these separates the per-flag decoding and the tag, and shows that a pushed word carries only its own error. The same error-laden characters are then sent with the buffer full and in break-detect mode, which shows that overrun and break mode suppress the other flags rather than add to them. The read sequences are tried with data reads alone, with the full status-then-data pair, and with an error event recurring between the two reads. Together these tell the armed clear apart from an unconditional clear on data read.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  // Flag vector layout used across the block
  localparam int FLAG_PAR = 0;
  localparam int FLAG_FRM = 1;
  localparam int FLAG_NSE = 2;
  localparam int FLAG_OVR = 3;
  localparam int FLAG_IDL = 4;
  localparam int NUM_FLAGS = 5;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rxf_event_dec.sv
module rxf_event_dec
  import uart_rxf_pkg::*;
(
  input  logic      chr_done_i,
  input  logic      stop_bit_i,
  input  logic      par_bad_i,
  input  logic      par_en_i,
  input  logic      noise_i,
  input  logic      brk_mode_i,
  input  logic      brk_pend_i,
  input  logic      buf_full_i,
  input  logic      idle_evt_i,
  input  logic      ovr_q_i,
  input  logic      frm_q_i,
  output logic      push_o,
  output logic      push_perr_o,
  output flag_vec_t set_o
);
  logic live;
  logic ovr_hit;
  logic good;
  logic chk_en;

  always_comb begin
    // A pending framing error blocks reception entirely
    live    = chr_done_i & ~frm_q_i;
    // Overrun: no room, an already-set overrun, or an uncleared break
    ovr_hit = live & (ovr_q_i | buf_full_i | (brk_mode_i & brk_pend_i));
    good    = live & ~ovr_hit;
    chk_en  = good & ~brk_mode_i;

    set_o           = '0;
    set_o[FLAG_OVR] = ovr_hit;
    set_o[FLAG_PAR] = chk_en & par_en_i & par_bad_i;
    set_o[FLAG_FRM] = chk_en & ~stop_bit_i;
    set_o[FLAG_NSE] = chk_en & noise_i;
    set_o[FLAG_IDL] = idle_evt_i & ~ovr_q_i;

    push_o      = good;
    push_perr_o = chk_en & par_en_i & par_bad_i;
  end
endmodule

// File: rtl/rxf_sticky_bit.sv
module rxf_sticky_bit (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic upd_en;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    upd_en = set_i | stat_rd_i | data_rd_i;
    if (set_i) begin
      // New event wins and cancels any pending clear
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else begin
      if (data_rd_i) begin
        arm_d = 1'b0;
        if (arm_q) flag_d = 1'b0;
      end
      if (stat_rd_i && flag_q && !(data_rd_i && arm_q)) arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R10
  clr_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(arm_q && data_rd_i));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/rxf_rdy_gate.sv
module rxf_rdy_gate (
  input  logic clk,
  input  logic rst_ni,
  input  logic nempty_i,
  input  logic block_i,
  output logic rdy_o
);
  logic rdy_q, rdy_d;

  always_comb begin
    // May stay high under a block, but may not rise
    rdy_d = nempty_i & (rdy_q | ~block_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rdy_d;
  end

  assign rdy_o = rdy_q;

  // R5
  rdy_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rdy_q) |-> !$past(block_i));
endmodule

// File: rtl/uart_rx_flag_ctrl.sv
module uart_rx_flag_ctrl
  import uart_rxf_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chr_done,
  input  logic stop_bit,
  input  logic par_bad,
  input  logic par_en,
  input  logic noise_hit,
  input  logic brk_mode,
  input  logic brk_pend,
  input  logic buf_full,
  input  logic buf_nempty,
  input  logic idle_evt,
  input  logic stat_rd,
  input  logic data_rd,
  output logic push,
  output logic push_perr,
  output logic ovr_flg,
  output logic nse_flg,
  output logic frm_flg,
  output logic par_flg,
  output logic idle_flg,
  output logic rdy_flg
);
  localparam int SYNC_W = (RST_SYNC_STAGES < 1) ? 1 : RST_SYNC_STAGES;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_W-1:0] rst_pipe_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_W-1];

  flag_vec_t set_vec;
  flag_vec_t flag_vec;

  rxf_event_dec u_dec (
    .chr_done_i  (chr_done),
    .stop_bit_i  (stop_bit),
    .par_bad_i   (par_bad),
    .par_en_i    (par_en),
    .noise_i     (noise_hit),
    .brk_mode_i  (brk_mode),
    .brk_pend_i  (brk_pend),
    .buf_full_i  (buf_full),
    .idle_evt_i  (idle_evt),
    .ovr_q_i     (flag_vec[FLAG_OVR]),
    .frm_q_i     (flag_vec[FLAG_FRM]),
    .push_o      (push),
    .push_perr_o (push_perr),
    .set_o       (set_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rxf_sticky_bit u_bit (
      .clk       (clk),
      .rst_ni    (rst_sync_n),
      .set_i     (set_vec[g]),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .flag_o    (flag_vec[g])
    );
  end

  rxf_rdy_gate u_rdy (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .nempty_i (buf_nempty),
    .block_i  (flag_vec[FLAG_OVR]),
    .rdy_o    (rdy_flg)
  );

  assign ovr_flg  = flag_vec[FLAG_OVR];
  assign nse_flg  = flag_vec[FLAG_NSE];
  assign frm_flg  = flag_vec[FLAG_FRM];
  assign par_flg  = flag_vec[FLAG_PAR];
  assign idle_flg = flag_vec[FLAG_IDL];

  // R3
  full_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chr_done && buf_full && !frm_flg) |-> (!push ##1 ovr_flg));

  // R4
  ovr_no_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovr_flg |-> !push);

  // R5
  idle_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(idle_flg) |-> !$past(ovr_flg));

  // R6
  frm_no_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frm_flg |-> !push);

  // R7
  tag_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    push_perr |-> (push && par_en && !brk_mode && par_bad));

  // R9
  brk_no_noise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(nse_flg) |-> !$past(brk_mode));
endmodule

// File: tb/sim_uart_rx_flag_ctrl.sv
module sim_uart_rx_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_done = 0, stop_bit = 1, par_bad = 0, par_en = 0, noise_hit = 0;
  logic brk_mode = 0, brk_pend = 0, buf_full = 0, buf_nempty = 0, idle_evt = 0;
  logic stat_rd = 0, data_rd = 0;
  logic push, push_perr, ovr_flg, nse_flg, frm_flg, par_flg, idle_flg, rdy_flg;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_rx_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chr_done(chr_done), .stop_bit(stop_bit),
    .par_bad(par_bad), .par_en(par_en), .noise_hit(noise_hit),
    .brk_mode(brk_mode), .brk_pend(brk_pend), .buf_full(buf_full),
    .buf_nempty(buf_nempty), .idle_evt(idle_evt), .stat_rd(stat_rd),
    .data_rd(data_rd), .push(push), .push_perr(push_perr),
    .ovr_flg(ovr_flg), .nse_flg(nse_flg), .frm_flg(frm_flg),
    .par_flg(par_flg), .idle_flg(idle_flg), .rdy_flg(rdy_flg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {ovr, nse, frm, par, idle}
  function automatic int flags();
    return {ovr_flg, nse_flg, frm_flg, par_flg, idle_flg};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Send one character; returns push and tag seen in its completion cycle
  task automatic send_chr(input logic sb, input logic pb, input logic nz,
                          output logic pu, output logic tg);
    @(negedge clk);
    chr_done = 1; stop_bit = sb; par_bad = pb; noise_hit = nz;
    #1;
    pu = push; tg = push_perr;
    @(posedge clk); #1;
    chr_done = 0; stop_bit = 1; par_bad = 0; noise_hit = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1; @(posedge clk); #1; stat_rd = 0;
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1; @(posedge clk); #1; data_rd = 0;
  endtask

  task automatic pulse_idle();
    @(negedge clk); idle_evt = 1; @(posedge clk); #1; idle_evt = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags in reset", flags(), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) tick();
    chk("R1 flags after reset", flags(), 0);
    chk("R1 rdy after reset", rdy_flg, 0);
    chk("R1 push idle", push, 0);
  endtask

  task automatic t_clean();
    logic pu, tg;
    send_chr(1, 0, 0, pu, tg);
    chk("R2 clean push", pu, 1);
    chk("R2 clean tag", tg, 0);
    chk("R2 clean no flags", flags(), 0);
  endtask

  task automatic t_parity();
    logic pu, tg;
    par_en = 0;
    send_chr(1, 1, 0, pu, tg);
    chk("R7 parity off pushed", pu, 1);
    chk("R7 parity off tag", tg, 0);
    chk("R7 parity off flag", par_flg, 0);
    par_en = 1;
    send_chr(1, 1, 0, pu, tg);
    chk("R7 parity bad tag", tg, 1);
    chk("R7 parity flag set", par_flg, 1);
    send_chr(1, 0, 0, pu, tg);
    chk("R7 next word tag clean", tg, 0);
    rd_data();
    chk("R10 data read alone keeps par", par_flg, 1);
    rd_stat(); rd_data();
    chk("R10 two-step clears par", par_flg, 0);
    par_en = 0;
  endtask

  task automatic t_noise();
    logic pu, tg;
    send_chr(1, 0, 1, pu, tg);
    chk("R8 noisy pushed", pu, 1);
    chk("R8 noise flag", flags(), 5'b01000);
    rd_stat(); rd_data();
    chk("R10 noise cleared", nse_flg, 0);
  endtask

  task automatic t_frame();
    logic pu, tg;
    send_chr(0, 0, 0, pu, tg);
    chk("R6 framing char pushed", pu, 1);
    chk("R6 framing flag", flags(), 5'b00100);
    par_en = 1;
    send_chr(1, 1, 1, pu, tg);
    chk("R6 blocked while frm", pu, 0);
    chk("R6 blocked char sets nothing", flags(), 5'b00100);
    par_en = 0;
    rd_stat(); rd_data();
    chk("R10 frm cleared", frm_flg, 0);
    send_chr(1, 0, 0, pu, tg);
    chk("R6 reception resumes", pu, 1);
  endtask

  task automatic t_break();
    logic pu, tg;
    brk_mode = 1; par_en = 1;
    send_chr(0, 1, 1, pu, tg);
    chk("R9 break char pushed", pu, 1);
    chk("R9 break no tag", tg, 0);
    chk("R9 break no error flags", flags(), 0);
    brk_pend = 1;
    send_chr(1, 0, 0, pu, tg);
    chk("R9 pending break not pushed", pu, 0);
    chk("R9 pending break overrun", flags(), 5'b10000);
    brk_pend = 0; brk_mode = 0; par_en = 0;
    rd_stat(); rd_data();
    chk("R10 ovr cleared", ovr_flg, 0);
  endtask

  task automatic t_overrun();
    logic pu, tg;
    @(negedge clk); buf_nempty = 1;
    tick();
    chk("R5 rdy follows nonempty", rdy_flg, 1);
    par_en = 1; buf_full = 1;
    send_chr(0, 1, 1, pu, tg);
    chk("R3 full not pushed", pu, 0);
    chk("R3 only overrun", flags(), 5'b10000);
    chk("R5 rdy held while high", rdy_flg, 1);
    @(negedge clk); buf_nempty = 0; buf_full = 0;
    tick();
    chk("R5 rdy falls on empty", rdy_flg, 0);
    @(negedge clk); buf_nempty = 1;
    repeat (3) tick();
    chk("R5 rdy blocked under ovr", rdy_flg, 0);
    send_chr(0, 1, 1, pu, tg);
    chk("R4 no push with room", pu, 0);
    chk("R4 no error flags under ovr", flags(), 5'b10000);
    pulse_idle();
    chk("R5 idle blocked under ovr", idle_flg, 0);
    rd_stat(); rd_data();
    chk("R10 ovr cleared", ovr_flg, 0);
    tick();
    chk("R5 rdy rises after clear", rdy_flg, 1);
    @(negedge clk); buf_nempty = 0; par_en = 0;
    tick();
  endtask

  task automatic t_idle();
    pulse_idle();
    chk("R12 idle set", idle_flg, 1);
    rd_data();
    chk("R12 idle kept on data read", idle_flg, 1);
    rd_stat(); rd_data();
    chk("R12 idle cleared", idle_flg, 0);
  endtask

  task automatic t_rearm();
    logic pu, tg;
    buf_full = 1;
    send_chr(1, 0, 0, pu, tg);
    chk("R3 overrun set", ovr_flg, 1);
    rd_stat();
    send_chr(1, 0, 0, pu, tg);
    rd_data();
    chk("R11 re-event keeps ovr", ovr_flg, 1);
    buf_full = 0;
    rd_stat(); rd_data();
    chk("R11 later clear works", ovr_flg, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_clean();
    t_parity();
    t_noise();
    t_frame();
    t_break();
    t_overrun();
    t_idle();
    t_rearm();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule